// File: doc/BRIEF.md
# Flash page program buffer

This block sits behind the serial command decoder of a NOR flash model and handles the data phase of a page program command. Once the decoder has the three address bytes, it pulses a start strobe with the full byte address. Each data byte that follows is stored in a 256-entry page buffer. The first byte goes to the lane given by the low eight address bits, and the write pointer wraps from the top lane back to lane 0 of the same page. A per-lane written mask records which lanes received data. Because a later byte overwrites an earlier one in the same lane, only the most recent 256 bytes take effect.

When chip select rises, the block decides whether to commit. It commits only if the command ended exactly on a byte boundary, at least one data byte arrived, the write enable latch is set, and the target page is not protected. On commit, a sequencer walks the lanes in ascending order. For each written lane it reads the existing array byte through a synchronous read port, ANDs the new data into it (bits only go from 1 to 0), and writes the result back. Lanes that were not written are never touched.

After the walk, a timer holds the busy flag for a programmable number of clocks to model the self-timed program time. Busy then drops, and a one-cycle done pulse tells the status logic to clear the write enable latch. A refused or cancelled command raises neither busy nor done.

Top module: `pp_page_program`

## Requirements
- R1: The first data byte lands at in-page offset pp_addr[7:0] of page pp_addr[ADDR_W-1:8]. Each following byte goes to the next offset, wrapping from offset 0xFF to 0x00 within the same page.
- R2: When more than 256 bytes are sent, a byte overwrites any earlier byte at the same offset, so the last byte received for each offset is the one programmed.
- R3: Only offsets that received a byte in the current command are written to the array. Every other array byte keeps its value.
- R4: If chip select rises with cs_aligned = 0 (a partial final byte), nothing is written, busy stays 0 and done is not pulsed.
- R5: If chip select rises before any data byte arrives, nothing is written, busy stays 0 and done is not pulsed.
- R6: If chip select rises with wel = 0 or page_prot = 1, the command is refused: nothing is written, busy stays 0 and done is not pulsed.
- R7: After an accepted command, busy goes to 1 in the cycle after the chip-select rise is sampled. It stays 1 through the lane walk and then PROG_CYCLES further clocks. Array writes occur only while busy is 1. Busy falls in the same cycle that done is high for exactly one cycle.
- R8: Each programmed array byte becomes (old value AND new data). Lanes are written in ascending offset order, and for each lane the array read comes before its write.
- R9: While busy is 1, a new start strobe, its data bytes and its chip-select rise are ignored. They cause no writes and leave the running program unchanged.
- R10: Every array write addresses the page latched at the start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pp_begin | input | 1 | Start of a program data phase, one cycle |
| pp_addr | input | ADDR_W | Byte start address, valid with pp_begin |
| pp_byte_vld | input | 1 | A complete data byte is on pp_byte |
| pp_byte | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select has just risen, one cycle |
| cs_aligned | input | 1 | Clock count at the rise was a multiple of eight |
| wel | input | 1 | Write enable latch state |
| page_prot | input | 1 | Target page lies in the protected region |
| mem_rd_en | output | 1 | Array read strobe |
| mem_rd_addr | output | ADDR_W | Array read address |
| mem_rd_data | input | 8 | Array read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | Array write strobe |
| mem_wr_addr | output | ADDR_W | Array write address |
| mem_wr_data | output | 8 | Array write data |
| busy | output | 1 | Program cycle in progress |
| done | output | 1 | One-cycle pulse at the end of the program cycle |

## Verification
The bench builds the block with ADDR_W = 12 and PROG_CYCLES = 20, which gives a 16-page, 4 KB array. With this size the bench can keep a full shadow copy of the array and compare every byte after each command, so untouched lanes and neighbouring pages are checked along with the programmed ones. The short program time keeps each busy window to a few hundred clocks. That leaves room in the run for full-page wrap, overlong bursts, commands during busy and repeated programming of the same bytes.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int unsigned PP_OFF_W = 8;
  localparam int unsigned PP_LANES = 1 << PP_OFF_W;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_SCAN,
    SQ_READ,
    SQ_MERGE
  } seq_state_e;
endpackage

// File: rtl/pp_lane_buffer.sv
module pp_lane_buffer #(
  parameter int unsigned OFF_W = pp_pkg::PP_OFF_W,
  localparam int unsigned LANES = 1 << OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [OFF_W-1:0] rd_idx,
  output logic [7:0]       rd_data,
  output logic [LANES-1:0] lane_mask
);
  logic [7:0] store [LANES];
  logic [7:0] rd_q;

  // data storage: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
    rd_q <= store[rd_idx];
  end

  // written-lane mask, cleared at each command start
  always_ff @(posedge clk) begin
    if (rst || clr) lane_mask <= '0;
    else if (wr_en) lane_mask[wr_idx] <= 1'b1;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/pp_commit_seq.sv
module pp_commit_seq #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned OFF_W  = pp_pkg::PP_OFF_W,
  localparam int unsigned LANES  = 1 << OFF_W,
  localparam int unsigned PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [PAGE_W-1:0] page,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [7:0]        buf_data,
  output logic [OFF_W-1:0]  lane_idx,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              scan_done
);
  import pp_pkg::*;

  seq_state_e       state;
  logic [OFF_W-1:0] idx;
  logic             last_lane;

  assign last_lane = (idx == OFF_W'(LANES - 1));
  assign lane_idx  = idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= SQ_IDLE;
      idx         <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      mem_wr_en   <= 1'b0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
      scan_done   <= 1'b0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      scan_done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            idx   <= '0;
            state <= SQ_SCAN;
          end
        end
        SQ_SCAN: begin
          if (lane_mask[idx]) begin
            mem_rd_en   <= 1'b1;
            mem_rd_addr <= {page, idx};
            state       <= SQ_READ;
          end else if (last_lane) begin
            state     <= SQ_IDLE;
            scan_done <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        SQ_READ: begin
          // array samples the read address at the end of this cycle
          state <= SQ_MERGE;
        end
        SQ_MERGE: begin
          mem_wr_en   <= 1'b1;
          mem_wr_addr <= {page, idx};
          mem_wr_data <= mem_rd_data & buf_data;
          if (last_lane) begin
            state     <= SQ_IDLE;
            scan_done <= 1'b1;
          end else begin
            idx   <= idx + 1'b1;
            state <= SQ_SCAN;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pp_busy_timer.sv
module pp_busy_timer #(
  parameter int unsigned CYCLES = 1000,
  localparam int unsigned CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic running,
  output logic last,
  output logic expire
);
  logic [CNT_W-1:0] cnt;

  assign last = running && (cnt == CNT_W'(CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
      cnt     <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (start) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (last) begin
        running <= 1'b0;
        expire  <= 1'b1;
      end else if (running) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pp_page_program.sv
module pp_page_program #(
  parameter int unsigned ADDR_W      = 19,
  parameter int unsigned OFF_W       = pp_pkg::PP_OFF_W,
  parameter int unsigned PROG_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pp_begin,
  input  logic [ADDR_W-1:0] pp_addr,
  input  logic              pp_byte_vld,
  input  logic [7:0]        pp_byte,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel,
  input  logic              page_prot,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [7:0]        mem_wr_data,
  output logic              busy,
  output logic              done
);
  localparam int unsigned LANES  = 1 << OFF_W;
  localparam int unsigned PAGE_W = ADDR_W - OFF_W;

  logic              collecting;
  logic              got_byte;
  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  ptr_q;
  logic              busy_q;
  logic              open_cmd;
  logic              accept;
  logic              lb_wr;
  logic [7:0]        lb_rd_data;
  logic [LANES-1:0]  lb_mask;
  logic [OFF_W-1:0]  seq_idx;
  logic              scan_done;
  logic              tmr_running;
  logic              tmr_last;
  logic              tmr_expire;

  assign open_cmd = pp_begin && !busy_q;
  assign lb_wr    = collecting && pp_byte_vld;
  assign accept   = cs_rise && collecting && cs_aligned && got_byte && wel && !page_prot;

  // data-phase tracking: page latch, wrapping offset pointer, byte seen flag
  always_ff @(posedge clk) begin
    if (rst) begin
      collecting <= 1'b0;
      got_byte   <= 1'b0;
      page_q     <= '0;
      ptr_q      <= '0;
    end else if (open_cmd) begin
      collecting <= 1'b1;
      got_byte   <= 1'b0;
      page_q     <= pp_addr[ADDR_W-1:OFF_W];
      ptr_q      <= pp_addr[OFF_W-1:0];
    end else if (cs_rise) begin
      collecting <= 1'b0;
    end else if (lb_wr) begin
      got_byte <= 1'b1;
      ptr_q    <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           busy_q <= 1'b0;
    else if (accept)   busy_q <= 1'b1;
    else if (tmr_last) busy_q <= 1'b0;
  end

  pp_lane_buffer #(.OFF_W(OFF_W)) u_lanes (
    .clk       (clk),
    .rst       (rst),
    .clr       (open_cmd),
    .wr_en     (lb_wr),
    .wr_idx    (ptr_q),
    .wr_data   (pp_byte),
    .rd_idx    (seq_idx),
    .rd_data   (lb_rd_data),
    .lane_mask (lb_mask)
  );

  pp_commit_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .page        (page_q),
    .lane_mask   (lb_mask),
    .buf_data    (lb_rd_data),
    .lane_idx    (seq_idx),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_data (mem_wr_data),
    .scan_done   (scan_done)
  );

  pp_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .start   (scan_done),
    .running (tmr_running),
    .last    (tmr_last),
    .expire  (tmr_expire)
  );

  assign busy = busy_q;
  assign done = tmr_expire;
endmodule

// File: rtl/pp_page_program_chk.sv
module pp_page_program_chk #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned OFF_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise,
  input logic              cs_aligned,
  input logic              wel,
  input logic              page_prot,
  input logic              collecting,
  input logic              got_byte,
  input logic              busy,
  input logic              done,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [ADDR_W-OFF_W-1:0] page_q
);
  // R10
  wr_in_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wr_addr[ADDR_W-1:OFF_W] == page_q));

  // R7
  wr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> busy);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise && collecting));

  // R4
  partial_cancel_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !cs_aligned && !busy) |=> !busy);

  // R5
  empty_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && !got_byte && !busy) |=> !busy);

  // R6
  refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_rise && (!wel || page_prot) && !busy) |=> !busy);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en));
endmodule

bind pp_page_program pp_page_program_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_rise     (cs_rise),
  .cs_aligned  (cs_aligned),
  .wel         (wel),
  .page_prot   (page_prot),
  .collecting  (collecting),
  .got_byte    (got_byte),
  .busy        (busy),
  .done        (done),
  .mem_rd_en   (mem_rd_en),
  .mem_wr_en   (mem_wr_en),
  .mem_wr_addr (mem_wr_addr),
  .page_q      (page_q)
);

// File: tb/pp_page_program_bench.sv
module pp_page_program_bench;
  localparam int AW    = 12;
  localparam int OW    = 8;
  localparam int PC    = 20;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          pp_begin = 1'b0;
  logic [AW-1:0] pp_addr = '0;
  logic          pp_byte_vld = 1'b0;
  logic [7:0]    pp_byte = '0;
  logic          cs_rise = 1'b0;
  logic          cs_aligned = 1'b0;
  logic          wel = 1'b0;
  logic          page_prot = 1'b0;
  logic          mem_rd_en;
  logic [AW-1:0] mem_rd_addr;
  logic [7:0]    mem_rd_data;
  logic          mem_wr_en;
  logic [AW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic          busy;
  logic          done;

  always #10 clk = ~clk;

  pp_page_program #(.ADDR_W(AW), .OFF_W(OW), .PROG_CYCLES(PC)) u_pp_page_program (
    .clk(clk), .rst(rst), .pp_begin(pp_begin), .pp_addr(pp_addr),
    .pp_byte_vld(pp_byte_vld), .pp_byte(pp_byte), .cs_rise(cs_rise),
    .cs_aligned(cs_aligned), .wel(wel), .page_prot(page_prot),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 53 + 17) ^ 8'(i >> 4);
  endfunction

  function automatic logic [7:0] byte_of(input int seed, input int k);
    return 8'(seed * 7 + k * 29 + (k >> 2)) | 8'(seed);
  endfunction

  // array model: synchronous read, plain write
  logic [7:0] ram [DEPTH];
  logic [7:0] rdq;
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= init_val(i);
      rdq <= '0;
    end else begin
      if (mem_rd_en) rdq <= ram[mem_rd_addr];
      if (mem_wr_en) ram[mem_wr_addr] <= mem_wr_data;
    end
  end
  assign mem_rd_data = rdq;

  logic [7:0] shadow [DEPTH];

  typedef struct {
    logic [AW-1:0] a;
    logic [7:0]    d;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  int vectors = 0;
  int fails   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // monitor: every array write is compared against the next expected item
  always @(negedge clk) begin
    if (!rst && mem_wr_en) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R3 unexpected write at %0h: actual %0h expected none",
                 mem_wr_addr, mem_wr_data);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.a !== mem_wr_addr || e.d !== mem_wr_data) begin
          fails++;
          $display("FAIL %s write: actual %0h@%0h expected %0h@%0h",
                   e.tag, mem_wr_data, mem_wr_addr, e.d, e.a);
        end
      end
    end
  end

  // driver side: compute expected writes for an accepted command
  task automatic expect_op(input int page, input int off, input int n,
                           input int seed, input string tag);
    logic [7:0] ld [256];
    bit         lm [256];
    for (int l = 0; l < 256; l++) begin ld[l] = '0; lm[l] = 1'b0; end
    for (int k = 0; k < n; k++) begin
      ld[(off + k) % 256] = byte_of(seed, k);
      lm[(off + k) % 256] = 1'b1;
    end
    for (int l = 0; l < 256; l++) begin
      if (lm[l]) begin
        exp_t e;
        e.a = AW'(page * 256 + l);
        e.d = shadow[page * 256 + l] & ld[l];
        e.tag = tag;
        shadow[page * 256 + l] = e.d;
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic drive_op(input int page, input int off, input int n, input int seed,
                          input bit aligned, input bit w, input bit p);
    @(posedge clk); #2;
    pp_begin = 1'b1;
    pp_addr  = AW'(page * 256 + off);
    wel = w;
    page_prot = p;
    @(posedge clk); #2;
    pp_begin = 1'b0;
    for (int k = 0; k < n; k++) begin
      pp_byte_vld = 1'b1;
      pp_byte = byte_of(seed, k);
      @(posedge clk); #2;
    end
    pp_byte_vld = 1'b0;
    cs_rise = 1'b1;
    cs_aligned = aligned;
    @(posedge clk); #2;
    cs_rise = 1'b0;
  endtask

  task automatic compare_mem(input string tag);
    int mis = 0;
    int first = -1;
    for (int i = 0; i < DEPTH; i++)
      if (ram[i] !== shadow[i]) begin
        mis++;
        if (first < 0) first = i;
      end
    check(mis == 0, tag, "array contents mismatching bytes", mis, 0);
  endtask

  task automatic wait_result(input bit accept, input int minb, input string tag);
    if (accept) begin
      int bc = 0;
      @(negedge clk);
      while (busy && bc < 5000) begin
        bc++;
        @(negedge clk);
      end
      check(bc >= minb && bc <= 3 * 256 + PC + 4, "R7", "busy length", bc, minb);
      check(done === 1'b1, "R7", "done as busy falls", done, 1);
      @(negedge clk);
      check(done === 1'b0, "R7", "done one cycle", done, 0);
    end else begin
      bit saw = 1'b0;
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        if (busy || done) saw = 1'b1;
      end
      check(!saw, tag, "busy/done after refused command", saw, 0);
    end
    check(exp_q.size() == 0, tag, "missing writes", exp_q.size(), 0);
    compare_mem(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) shadow[i] = init_val(i);
    repeat (4) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && mem_wr_en === 1'b0, "R7",
          "outputs in reset", {busy, done, mem_wr_en}, 0);
    @(posedge clk); #2;
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R7", "idle after reset", {busy, done}, 0);

    // R1 R3 R8: short burst mid page
    expect_op(3, 8'h10, 4, 1, "R1");
    drive_op(3, 8'h10, 4, 1, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 256 + PC, "R1");

    // R8: program the same bytes again with new data (AND into old)
    expect_op(3, 8'h10, 6, 9, "R8");
    drive_op(3, 8'h10, 6, 9, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 256 + PC, "R8");

    // R1: wrap from offset 0xFF to 0x00 in the same page
    expect_op(5, 8'hFE, 5, 2, "R1");
    drive_op(5, 8'hFE, 5, 2, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 256 + PC, "R1");

    // R2: 300 bytes, last 256 survive
    expect_op(6, 8'h20, 300, 3, "R2");
    drive_op(6, 8'h20, 300, 3, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 256 + PC, "R2");

    // R4: partial final byte cancels
    drive_op(7, 8'h00, 3, 4, 1'b0, 1'b1, 1'b0);
    wait_result(1'b0, 0, "R4");

    // R5: no data byte
    drive_op(7, 8'h40, 0, 5, 1'b1, 1'b1, 1'b0);
    wait_result(1'b0, 0, "R5");

    // R6: write enable latch clear, then protected page
    drive_op(8, 8'h00, 8, 6, 1'b1, 1'b0, 1'b0);
    wait_result(1'b0, 0, "R6");
    drive_op(8, 8'h00, 8, 7, 1'b1, 1'b1, 1'b1);
    wait_result(1'b0, 0, "R6");

    // R9 R10: second command during busy is ignored
    expect_op(9, 8'h80, 3, 8, "R9");
    drive_op(9, 8'h80, 3, 8, 1'b1, 1'b1, 1'b0);
    drive_op(10, 8'h00, 4, 11, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 0, "R9");

    // R3: a single byte at the top lane of the last page
    expect_op(15, 8'hFF, 1, 12, "R3");
    drive_op(15, 8'hFF, 1, 12, 1'b1, 1'b1, 1'b0);
    wait_result(1'b1, 256 + PC, "R3");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule